// File: doc/BRIEF.md
# Multi-Enable Interrupt Pending Aggregator

This block collects a fixed set of interrupt sources and decides which of them are pending. Each source has an assert line and a number of independent enables. Every source has its own required number of enables. Each enable arrives as a strobe that raises or lowers the source's enable count by one. A source becomes pending only when its assert line is high and its enable count has reached the required total for that source.

The block keeps a running count of pending sources. It drives one CPU interrupt request line that is high exactly while that count is non-zero. When the CPU asks for a vector, it presents a query strobe together with its current mask level. The block answers with the vector code of the lowest-numbered pending source and a valid flag.

Per-source required totals and vector codes are parameters. Source 0 is reserved.

Top module: `irq_pend_agg`

## Requirements
- R1: After reset, `cpu_irq`, `vec_valid` and `vec_code` are all 0, and every enable count and assert state is cleared.
- R2: Source i is pending once its assert line is high and its enable count equals its parameter total REQ_TOTAL[i]. The count starts at 0 and moves by one per strobe. With the default totals 0,1,2,3,0,1,2,1 for sources 0..7, source 3 needs three net raise strobes.
- R3: A raise strobe is ignored when the count already equals the source's total. A lower strobe is ignored when the count is 0.
- R4: A raise strobe and a lower strobe for the same source in the same cycle leave that source's count unchanged.
- R5: `cpu_irq` is high exactly when at least one source is pending. It changes at the same clock edge that samples the stimulus which makes the first source pending or the last source non-pending.
- R6: Holding an assert line at the same level has no further effect. The line's value is acted on only when it changes.
- R7: Source 0 is reserved. It never becomes pending, and its assert line and enable strobes have no effect on `cpu_irq` or on query results.
- R8: A query with mask level 4'hF returns `vec_valid`=0 and `vec_code`=0.
- R9: Any other query returns `vec_valid`=1 and the code VEC_CODE[i] of the lowest-index pending source i. The default codes are 'h200 + 'h20*i. The result is based on the pending state just before the query edge and is visible after that edge.
- R10: A query that finds no pending source returns `vec_valid`=0 and `vec_code`=0.
- R11: `vec_valid` and `vec_code` hold their values in cycles without a query.
- R12: A source whose total is 0 is pending whenever its assert line is high, with no enable strobe needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | NUM_SRC | Per-source assert level |
| en_up | input | NUM_SRC | Per-source enable raise strobe |
| en_dn | input | NUM_SRC | Per-source enable lower strobe |
| query | input | 1 | Vector query strobe |
| mask_lvl | input | 4 | CPU interrupt mask level presented with the query |
| cpu_irq | output | 1 | CPU interrupt request |
| vec_valid | output | 1 | Last query found a vector |
| vec_code | output | VEC_W | Vector code of the last query |

## Verification
Levels and strobes presented before a rising edge are reflected in `cpu_irq` right after that edge, since one register stage sits between them. A query returns its answer after the edge that samples it. That answer reflects the pending set as it was one edge earlier, so a query issued together with a change does not yet see the change. The scoreboard records each expected result tagged with the cycle at which it is due. Inputs are driven and outputs compared on falling edges, and the monitor pops an entry only once its due cycle has been reached.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int MASK_W = 4;
    localparam logic [MASK_W-1:0] MASK_ALL = 4'hF;
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot #(
    parameter int CNT_W    = 2,
    parameter int TOTAL    = 1,
    parameter bit RESERVED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic up_i,
    input  logic dn_i,
    output logic pend_o,
    output logic rise_o,
    output logic fall_o
);
    localparam logic [CNT_W-1:0] TOT_C = CNT_W'(TOTAL);

    typedef struct packed {
        logic             asserted;
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (!RESERVED) begin
            slot_d.asserted = level_i;
            if (up_i && !dn_i && (slot_q.cnt != TOT_C)) begin
                slot_d.cnt = slot_q.cnt + 1'b1;
            end else if (dn_i && !up_i && (slot_q.cnt != '0)) begin
                slot_d.cnt = slot_q.cnt - 1'b1;
            end
            slot_d.pend = slot_d.asserted && (slot_d.cnt == TOT_C);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign pend_o = slot_q.pend;
    assign rise_o = slot_d.pend & ~slot_q.pend;
    assign fall_o = ~slot_d.pend & slot_q.pend;
endmodule

// File: rtl/irq_pend_count.sv
module irq_pend_count #(
    parameter int NUM_SRC = 8,
    parameter int PCNT_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] rise_i,
    input  logic [NUM_SRC-1:0] fall_i,
    output logic [PCNT_W-1:0]  cnt_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [PCNT_W-1:0] cnt;
        logic              irq;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + PCNT_W'($countones(rise_i)) - PCNT_W'($countones(fall_i));
        st_d.irq = (st_d.cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign irq_o = st_q.irq;
endmodule

// File: rtl/irq_vec_select.sv
module irq_vec_select
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 12,
    parameter int unsigned VEC_CODE [NUM_SRC] = '{'h200, 'h220, 'h240, 'h260, 'h280, 'h2A0, 'h2C0, 'h2E0}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic               query_i,
    input  logic [MASK_W-1:0]  mask_i,
    output logic               valid_o,
    output logic [VEC_W-1:0]   code_o
);
    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] code;
    } sel_t;

    sel_t sel_d, sel_q;
    logic             hit;
    logic [VEC_W-1:0] hit_code;

    always_comb begin
        hit      = 1'b0;
        hit_code = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                hit      = 1'b1;
                hit_code = VEC_W'(VEC_CODE[i]);
            end
        end
    end

    always_comb begin
        sel_d = sel_q;
        if (query_i) begin
            if ((mask_i == MASK_ALL) || !hit) begin
                sel_d.valid = 1'b0;
                sel_d.code  = '0;
            end else begin
                sel_d.valid = 1'b1;
                sel_d.code  = hit_code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign valid_o = sel_q.valid;
    assign code_o  = sel_q.code;
endmodule

// File: rtl/irq_pend_agg.sv
module irq_pend_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int MAX_EN  = 3,
    parameter int VEC_W   = 12,
    parameter int unsigned REQ_TOTAL [NUM_SRC] = '{0, 1, 2, 3, 0, 1, 2, 1},
    parameter int unsigned VEC_CODE  [NUM_SRC] = '{'h200, 'h220, 'h240, 'h260, 'h280, 'h2A0, 'h2C0, 'h2E0}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_level,
    input  logic [NUM_SRC-1:0] en_up,
    input  logic [NUM_SRC-1:0] en_dn,
    input  logic               query,
    input  logic [MASK_W-1:0]  mask_lvl,
    output logic               cpu_irq,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_code
);
    localparam int CNT_W  = $clog2(MAX_EN + 1);
    localparam int PCNT_W = $clog2(NUM_SRC + 1);

    logic [NUM_SRC-1:0] pend_vec;
    logic [NUM_SRC-1:0] rise_vec;
    logic [NUM_SRC-1:0] fall_vec;
    logic [PCNT_W-1:0]  pend_cnt;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        irq_src_slot #(
            .CNT_W   (CNT_W),
            .TOTAL   (int'(REQ_TOTAL[g])),
            .RESERVED(g == 0)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .level_i(src_level[g]),
            .up_i   (en_up[g]),
            .dn_i   (en_dn[g]),
            .pend_o (pend_vec[g]),
            .rise_o (rise_vec[g]),
            .fall_o (fall_vec[g])
        );
    end

    irq_pend_count #(
        .NUM_SRC(NUM_SRC),
        .PCNT_W (PCNT_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .rise_i(rise_vec),
        .fall_i(fall_vec),
        .cnt_o (pend_cnt),
        .irq_o (cpu_irq)
    );

    irq_vec_select #(
        .NUM_SRC (NUM_SRC),
        .VEC_W   (VEC_W),
        .VEC_CODE(VEC_CODE)
    ) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend_vec),
        .query_i(query),
        .mask_i (mask_lvl),
        .valid_o(vec_valid),
        .code_o (vec_code)
    );
endmodule

// File: rtl/irq_pend_agg_chk.sv
module irq_pend_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int PCNT_W  = 4,
    parameter int VEC_W   = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_level,
    input logic               query,
    input logic [MASK_W-1:0]  mask_lvl,
    input logic               cpu_irq,
    input logic               vec_valid,
    input logic [VEC_W-1:0]   vec_code,
    input logic [NUM_SRC-1:0] pend_vec,
    input logic [PCNT_W-1:0]  pend_cnt
);
    p_irq_follows_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == (pend_vec != '0));

    p_count_matches_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pend_cnt) == $countones(pend_vec));

    p_pend_needs_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_vec & ~$past(src_level)) == '0));

    p_reserved_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_vec[0]);

    p_full_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (query && (mask_lvl == MASK_ALL)) |=> (!vec_valid && (vec_code == '0)));

    p_query_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (query && (mask_lvl != MASK_ALL) && (pend_vec != '0)) |=> vec_valid);

    p_empty_query_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (query && (pend_vec == '0)) |=> !vec_valid);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !query |=> ($stable(vec_valid) && $stable(vec_code)));
endmodule

bind irq_pend_agg irq_pend_agg_chk #(
    .NUM_SRC(NUM_SRC),
    .PCNT_W (PCNT_W),
    .VEC_W  (VEC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_level(src_level),
    .query    (query),
    .mask_lvl (mask_lvl),
    .cpu_irq  (cpu_irq),
    .vec_valid(vec_valid),
    .vec_code (vec_code),
    .pend_vec (pend_vec),
    .pend_cnt (pend_cnt)
);

// File: tb/irq_pend_agg_test.sv
module irq_pend_agg_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int VW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_level = '0;
    logic [N-1:0]  en_up = '0;
    logic [N-1:0]  en_dn = '0;
    logic          query = 1'b0;
    logic [3:0]    mask_lvl = '0;
    logic          cpu_irq;
    logic          vec_valid;
    logic [VW-1:0] vec_code;

    int checks = 0;
    int failures = 0;
    int cyc_cnt = 0;
    bit done = 1'b0;

    int tot [N] = '{0, 1, 2, 3, 0, 1, 2, 1};
    int m_cnt [N];
    bit m_pend [N];
    bit m_valid = 1'b0;
    int m_code = 0;

    typedef struct {
        string tag;
        int    due;
        bit    irq;
        bit    valid;
        int    code;
    } exp_t;
    exp_t sb [$];

    irq_pend_agg uut (
        .clk(clk), .rst_n(rst_n), .src_level(src_level), .en_up(en_up),
        .en_dn(en_dn), .query(query), .mask_lvl(mask_lvl), .cpu_irq(cpu_irq),
        .vec_valid(vec_valid), .vec_code(vec_code)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected outputs.
    task automatic cyc(string tag, logic [N-1:0] up, logic [N-1:0] dn, bit q, logic [3:0] mk);
        exp_t e;
        bit any;
        en_up = up; en_dn = dn; query = q; mask_lvl = mk;
        if (q) begin
            m_valid = 1'b0; m_code = 0;
            if (mk != 4'hF) begin
                for (int i = N - 1; i >= 1; i--) begin
                    if (m_pend[i]) begin
                        m_valid = 1'b1; m_code = 'h200 + 'h20 * i;
                    end
                end
            end
        end
        any = 1'b0;
        for (int i = 1; i < N; i++) begin
            if (up[i] && !dn[i] && m_cnt[i] != tot[i]) m_cnt[i]++;
            else if (dn[i] && !up[i] && m_cnt[i] != 0) m_cnt[i]--;
            m_pend[i] = src_level[i] && (m_cnt[i] == tot[i]);
            any |= m_pend[i];
        end
        e.tag = tag; e.due = cyc_cnt + 1; e.irq = any; e.valid = m_valid; e.code = m_code;
        sb.push_back(e);
        @(negedge clk);
        en_up = '0; en_dn = '0; query = 1'b0;
    endtask

    // Monitor: compares each queued item once its due cycle is reached.
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0 && sb[0].due <= cyc_cnt) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " cpu_irq"}, int'(cpu_irq), int'(e.irq));
            check({e.tag, " vec_valid"}, int'(vec_valid), int'(e.valid));
            check({e.tag, " vec_code"}, int'(vec_code), e.code);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_pend[i] = 1'b0; end
        repeat (3) @(negedge clk);
        check("R1 reset cpu_irq", int'(cpu_irq), 0);
        check("R1 reset vec_valid", int'(vec_valid), 0);
        check("R1 reset vec_code", int'(vec_code), 0);
        rst_n = 1'b1;
        cyc("R10 empty query", '0, '0, 1, 4'h0);
        src_level[1] = 1'b1;
        cyc("R2 src1 enable", 8'h02, '0, 0, 4'h0);
        cyc("R9 query src1", '0, '0, 1, 4'h0);
        cyc("R11 hold a", '0, '0, 0, 4'h0);
        cyc("R11 hold b", '0, '0, 0, 4'hF);
        cyc("R6 level held a", '0, '0, 0, 4'h0);
        cyc("R6 level held b", '0, '0, 0, 4'h0);
        src_level[3] = 1'b1;
        cyc("R2 src3 step1", 8'h08, '0, 0, 4'h0);
        cyc("R2 src3 step2", 8'h08, '0, 0, 4'h0);
        cyc("R2 src3 step3", 8'h08, '0, 0, 4'h0);
        cyc("R3 raise at full", 8'h08, '0, 0, 4'h0);
        cyc("R9 query two pending", '0, '0, 1, 4'h3);
        src_level[1] = 1'b0;
        cyc("R5 src1 drops", '0, '0, 0, 4'h0);
        cyc("R9 query src3", '0, '0, 1, 4'hE);
        cyc("R3 lower from full", '0, 8'h08, 0, 4'h0);
        cyc("R3 lower b", '0, 8'h08, 0, 4'h0);
        cyc("R3 lower c", '0, 8'h08, 0, 4'h0);
        cyc("R3 lower at zero", '0, 8'h08, 0, 4'h0);
        cyc("R3 raise again a", 8'h08, '0, 0, 4'h0);
        cyc("R3 raise again b", 8'h08, '0, 0, 4'h0);
        cyc("R3 raise again c", 8'h08, '0, 0, 4'h0);
        src_level[2] = 1'b1;
        cyc("R4 both at zero", 8'h04, 8'h04, 0, 4'h0);
        cyc("R4 single raise", 8'h04, '0, 0, 4'h0);
        cyc("R4 both at one", 8'h04, 8'h04, 0, 4'h0);
        cyc("R4 second raise", 8'h04, '0, 0, 4'h0);
        cyc("R9 query src2", '0, '0, 1, 4'h0);
        src_level[0] = 1'b1;
        cyc("R7 reserved raise a", 8'h01, '0, 0, 4'h0);
        cyc("R7 reserved raise b", 8'h01, '0, 0, 4'h0);
        cyc("R7 reserved query", '0, '0, 1, 4'h0);
        cyc("R8 full mask", '0, '0, 1, 4'hF);
        src_level[2] = 1'b0; src_level[3] = 1'b0;
        cyc("R7 only reserved left", '0, '0, 0, 4'h0);
        src_level[4] = 1'b1;
        cyc("R12 zero total source", '0, '0, 0, 4'h0);
        cyc("R12 query src4", '0, '0, 1, 4'h0);
        src_level = '0;
        cyc("R5 last drops", '0, '0, 0, 4'h0);
        cyc("R10 query none", '0, '0, 1, 4'h0);
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            checks++; failures++;
            $display("FAIL scoreboard actual=%0d expected=0 pending items", sb.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule